// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port Register Front End

This block is the software-facing half of a simple serial port. A 32-bit register bus reaches a small set of word registers. Through them software fills a transmit byte queue, drains a receive byte queue, sets the line enables, the stop-bit count and the bit-period divisor, and arms two level-based interrupt sources. The bit-level shifters sit outside the block. The transmit shifter pulls bytes from a pop port. The receive shifter hands finished bytes to a push port.

Each data register reports its own status. The transmit data word shows "queue full" in bit 31. The receive data word shows "queue empty" in bit 31. Interrupts do not come from line events. They come from programmable fill levels: the transmit source is pending while the transmit queue holds fewer bytes than its threshold, and the receive source is pending while the receive queue holds more bytes than its threshold. The interrupt output is the OR of the pending sources that are enabled.

Top module: `wmk_uart_front`

## Requirements
- R1: After a synchronous active-low reset, the following hold: both queues are empty; the enables, the stop select, both thresholds, the interrupt mask and the divisor are zero; the interrupt output is low; a read of offset 0x00 returns 0; a read of offset 0x04 returns 0x8000_0000.
- R2: A write to offset 0x00 appends bits 7:0 to the transmit queue. While the queue is non-empty, `txq_valid` is high and `txq_byte` shows the oldest byte. Pulsing `txq_pop` removes that byte, so bytes leave in the order they were written.
- R3: The transmit queue holds 8 bytes. A read of offset 0x00 returns bit 31 set exactly when it is full, with all other bits zero. A write while it is full is discarded.
- R4: A read of offset 0x04 returns the oldest received byte in bits 7:0, with bit 31 clear, and removes that byte. When the receive queue is empty, the read returns exactly 0x8000_0000 and removes nothing.
- R5: The receive queue holds 8 bytes. A byte pushed while it is full is dropped, and the 8 bytes already held stay in order.
- R6: Offset 0x08 holds three fields: transmit enable in bit 0, stop select in bit 1 (0 means one stop bit, 1 means two), and a 3-bit transmit threshold in bits 18:16. It reads back with all other bits zero and drives `tx_enable` and `two_stop`.
- R7: Offset 0x0C holds the receive enable in bit 0 and a 3-bit receive threshold in bits 18:16. It reads back with all other bits zero and drives `rx_enable`.
- R8: Pending bit 0 (transmit) is set while the transmit queue level is below the transmit threshold. With a threshold of 1 it is set only when the queue is empty.
- R9: Pending bit 1 (receive) is set while the receive queue level is above the receive threshold. With a threshold of 0 it is set whenever at least one byte waits.
- R10: Offset 0x10 is the interrupt mask, with bit 0 for transmit and bit 1 for receive. `irq` is high exactly when some pending bit has its mask bit set.
- R11: Offset 0x14 reads the pending bits. Writes to it are ignored.
- R12: Offset 0x18 holds a 16-bit divisor, driven on `baud_div`, which gives a bit period of divisor+1 clocks. Upper bits are discarded and read as zero.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd` is high, and is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| txq_byte | output | 8 | Oldest transmit byte |
| txq_valid | output | 1 | Transmit queue not empty |
| txq_pop | input | 1 | Shifter takes the oldest transmit byte |
| rxq_byte | input | 8 | Byte from the receive shifter |
| rxq_push | input | 1 | Receive byte strobe |
| tx_enable | output | 1 | Transmit enable |
| rx_enable | output | 1 | Receive enable |
| two_stop | output | 1 | Two stop bits when high |
| baud_div | output | 16 | Bit period minus one, in clocks |
| irq | output | 1 | Level interrupt |

## Verification
Every register write, queue push and queue pop takes effect at the clock edge of its strobe. The pending bits and `irq` follow from the new queue levels in that same cycle, so direct port checks sample just after that edge. A read result lands on `bus_rdata` one edge after the read strobe. The driver queues the expected word when it issues the read, and the monitor compares it only in the cycle after a strobe was seen. Pending-bit reads are issued after the stimulus that changes a level, so each read sees the updated level.

// File: rtl/wmk_uart_pkg.sv
// Package: shared register offsets and widths for the serial port front end.
// Assumes a 32-bit word bus with byte addresses; word index = address[4:2].
package wmk_uart_pkg;
    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;

    // Word indexes of the registers (byte offset / 4)
    localparam logic [2:0] IDX_TX_PORT  = 3'd0;  // 0x00
    localparam logic [2:0] IDX_RX_PORT  = 3'd1;  // 0x04
    localparam logic [2:0] IDX_TX_CFG   = 3'd2;  // 0x08
    localparam logic [2:0] IDX_RX_CFG   = 3'd3;  // 0x0C
    localparam logic [2:0] IDX_IRQ_MASK = 3'd4;  // 0x10
    localparam logic [2:0] IDX_IRQ_STAT = 3'd5;  // 0x14
    localparam logic [2:0] IDX_BAUD_DIV = 3'd6;  // 0x18

    // Field positions shared by software and hardware
    localparam int FLAG_BIT   = 31;  // full / empty flag in the data words
    localparam int WM_LSB     = 16;  // threshold field start in the cfg words
    localparam int SRC_TX     = 0;   // transmit source in mask / pending
    localparam int SRC_RX     = 1;   // receive source in mask / pending
endpackage

// File: rtl/wmk_byte_fifo.sv
// Module: synchronous byte queue with occupancy count.
// Purpose: holds DEPTH entries; a push when full is discarded, a pop when
// empty is ignored; push and pop in one cycle are both honoured when legal.
// Assumes: single clock, synchronous active-low reset.
module wmk_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_ptr_q];
    assign level   = cnt_q;

    // Advance a pointer with wrap at DEPTH-1
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset needed on the data array
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R3 / R5: occupancy never exceeds the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R3 / R5: a push into a full queue without a pop leaves the level unchanged
    assert_full_push_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt_q == CNT_W'(DEPTH)));

    // R4: a pop of an empty queue without a push keeps it empty
    assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/wmk_irq_logic.sv
// Module: fill-level watermark comparators and interrupt combine.
// Purpose: transmit source pends while its level is below its threshold,
// receive source pends while its level is above its threshold; irq is the
// OR of enabled pending sources. Purely combinational.
module wmk_irq_logic #(
    parameter int CNT_W = 4,
    parameter int WM_W  = 3
) (
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [WM_W-1:0]  tx_thresh,
    input  logic [WM_W-1:0]  rx_thresh,
    input  logic [1:0]       mask,
    output logic [1:0]       pending,
    output logic             irq
);
    import wmk_uart_pkg::*;

    localparam int CMP_W = (CNT_W > WM_W) ? CNT_W : WM_W;

    logic [CMP_W-1:0] tx_l, rx_l, tx_t, rx_t;

    // Widen both sides to a common compare width
    always_comb begin
        tx_l = CMP_W'(tx_level);
        rx_l = CMP_W'(rx_level);
        tx_t = CMP_W'(tx_thresh);
        rx_t = CMP_W'(rx_thresh);
    end

    // Watermark comparisons
    always_comb begin
        pending         = '0;
        pending[SRC_TX] = (tx_l < tx_t);
        pending[SRC_RX] = (rx_l > rx_t);
    end

    // Level interrupt combine
    assign irq = |(pending & mask);
endmodule

// File: rtl/wmk_uart_front.sv
// Module: register bus front end of a watermark-interrupt serial port.
// Purpose: decodes a 32-bit word register bus, owns the two byte queues and
// the control, mask and divisor registers, and drives one level interrupt.
// Assumes: synchronous active-low reset; bus_wr and bus_rd not asserted in
// the same cycle; read data returned one cycle after the strobe.
module wmk_uart_front #(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 8,
    parameter int WM_W   = 3,
    parameter int DIV_W  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    output logic [7:0]          txq_byte,
    output logic                txq_valid,
    input  logic                txq_pop,
    input  logic [7:0]          rxq_byte,
    input  logic                rxq_push,
    output logic                tx_enable,
    output logic                rx_enable,
    output logic                two_stop,
    output logic [DIV_W-1:0]    baud_div,
    output logic                irq
);
    import wmk_uart_pkg::*;

    logic [2:0]        widx;
    logic              tx_en_q, tx_stop_q, rx_en_q;
    logic [WM_W-1:0]   tx_wm_q, rx_wm_q;
    logic [1:0]        mask_q;
    logic [DIV_W-1:0]  div_q;
    logic [31:0]       rdata_q, rdata_d;

    logic              tx_push, rx_pop;
    logic [7:0]        rx_head;
    logic [CNT_W-1:0]  tx_level, rx_level;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [1:0]        pending;

    assign widx = bus_addr[4:2];

    // Transmit queue push on a data write; receive pop on a data read
    assign tx_push = bus_wr && (widx == IDX_TX_PORT);
    assign rx_pop  = bus_rd && (widx == IDX_RX_PORT);

    wmk_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (bus_wdata[7:0]),
        .pop   (txq_pop),
        .dout  (txq_byte),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    wmk_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rxq_push),
        .din   (rxq_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    wmk_irq_logic #(.CNT_W(CNT_W), .WM_W(WM_W)) u_irq (
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_thresh (tx_wm_q),
        .rx_thresh (rx_wm_q),
        .mask      (mask_q),
        .pending   (pending),
        .irq       (irq)
    );

    // Control, mask and divisor register writes (pending bits are read-only)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q   <= 1'b0;
            tx_stop_q <= 1'b0;
            tx_wm_q   <= '0;
            rx_en_q   <= 1'b0;
            rx_wm_q   <= '0;
            mask_q    <= '0;
            div_q     <= '0;
        end else if (bus_wr) begin
            case (widx)
                IDX_TX_CFG: begin
                    tx_en_q   <= bus_wdata[0];
                    tx_stop_q <= bus_wdata[1];
                    tx_wm_q   <= bus_wdata[WM_LSB +: WM_W];
                end
                IDX_RX_CFG: begin
                    rx_en_q <= bus_wdata[0];
                    rx_wm_q <= bus_wdata[WM_LSB +: WM_W];
                end
                IDX_IRQ_MASK: mask_q <= bus_wdata[1:0];
                IDX_BAUD_DIV: div_q  <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer; unused bits and unmapped offsets give zero
    always_comb begin
        rdata_d = '0;
        if (bus_rd) begin
            case (widx)
                IDX_TX_PORT:  rdata_d[FLAG_BIT] = tx_full;
                IDX_RX_PORT: begin
                    rdata_d[FLAG_BIT] = rx_empty;
                    if (!rx_empty) rdata_d[7:0] = rx_head;
                end
                IDX_TX_CFG: begin
                    rdata_d[0] = tx_en_q;
                    rdata_d[1] = tx_stop_q;
                    rdata_d[WM_LSB +: WM_W] = tx_wm_q;
                end
                IDX_RX_CFG: begin
                    rdata_d[0] = rx_en_q;
                    rdata_d[WM_LSB +: WM_W] = rx_wm_q;
                end
                IDX_IRQ_MASK: rdata_d[1:0] = mask_q;
                IDX_IRQ_STAT: rdata_d[1:0] = pending;
                IDX_BAUD_DIV: rdata_d[DIV_W-1:0] = div_q;
                default: ;
            endcase
        end
    end

    // Registered read data, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign txq_valid = !tx_empty;
    assign tx_enable = tx_en_q;
    assign rx_enable = rx_en_q;
    assign two_stop  = tx_stop_q;
    assign baud_div  = div_q;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:WM_LSB+WM_W],
                           bus_wdata[WM_LSB-1:DIV_W > WM_LSB ? WM_LSB : DIV_W], rx_full};

    // R13: a cycle after no read carries zero read data
    assert_rdata_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R10: with nothing enabled the interrupt stays low
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b00) |-> !irq);

    // R8: a transmit queue at or above threshold never pends
    assert_tx_wm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level >= CNT_W'(tx_wm_q)) |-> !pending[SRC_TX]);

    // R9: an empty receive queue never pends
    assert_rx_wm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !pending[SRC_RX]);

    // R11: a write to the pending offset changes no configuration
    assert_stat_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == IDX_IRQ_STAT) |=> ($stable(mask_q) && $stable(div_q)));
endmodule

// File: tb/wmk_uart_front_tb.sv
// Bench: scoreboard of expected read words plus direct port checks.
module wmk_uart_front_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_wr, bus_rd, txq_pop, rxq_push;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  txq_byte, rxq_byte;
    logic        txq_valid, tx_enable, rx_enable, two_stop, irq;
    logic [15:0] baud_div;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen;

    always #2.5 clk = ~clk;  // 200 MHz

    wmk_uart_front u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .txq_byte(txq_byte), .txq_valid(txq_valid), .txq_pop(txq_pop),
        .rxq_byte(rxq_byte), .rxq_push(rxq_push), .tx_enable(tx_enable),
        .rx_enable(rx_enable), .two_stop(two_stop), .baud_div(baud_div), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data in the cycle after each strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R13: unexpected read data %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic line_pop();
        @(negedge clk); txq_pop = 1'b1;
        @(posedge clk); #1 txq_pop = 1'b0;
    endtask

    task automatic line_push(input logic [7:0] b);
        @(negedge clk); rxq_byte = b; rxq_push = 1'b1;
        @(posedge clk); #1 rxq_push = 1'b0;
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        txq_pop = 0; rxq_push = 0; rxq_byte = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 txq_valid", {31'b0, txq_valid}, 0);
        check("R1 enables", {29'b0, tx_enable, rx_enable, two_stop}, 0);
        check("R1 baud_div", {16'b0, baud_div}, 0);
        bus_read(5'h00, 32'h0, "R1 tx word");
        bus_read(5'h04, 32'h8000_0000, "R1 rx word");
        bus_read(5'h08, 32'h0, "R1 tx cfg");
        bus_read(5'h14, 32'h0, "R1 pending");

        // R6: transmit configuration fields
        bus_write(5'h08, 32'h0003_0003);
        bus_read(5'h08, 32'h0003_0003, "R6 tx cfg");
        check("R6 tx_enable", {31'b0, tx_enable}, 1);
        check("R6 two_stop", {31'b0, two_stop}, 1);
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h08, 32'h0007_0003, "R6 unused bits zero");
        bus_write(5'h08, 32'h0001_0001);
        check("R6 one stop", {31'b0, two_stop}, 0);

        // R8 / R10: threshold 1 pends on empty queue, mask gates irq
        bus_read(5'h14, 32'h1, "R8 empty pends");
        check("R10 masked", {31'b0, irq}, 0);
        bus_write(5'h10, 32'h1);
        check("R10 enabled tx", {31'b0, irq}, 1);
        bus_write(5'h00, 32'h0000_00A5);
        check("R8 one byte clears", {31'b0, irq}, 0);
        check("R2 valid", {31'b0, txq_valid}, 1);
        check("R2 head", {24'b0, txq_byte}, 32'hA5);
        bus_write(5'h00, 32'h0000_003C);
        line_pop();
        check("R2 order", {24'b0, txq_byte}, 32'h3C);
        line_pop();
        check("R2 drained", {31'b0, txq_valid}, 0);
        check("R8 refires", {31'b0, irq}, 1);

        // R3: full flag and discarded write
        for (int i = 0; i < 9; i++) bus_write(5'h00, 32'h10 + i);
        bus_read(5'h00, 32'h8000_0000, "R3 full flag");
        for (int i = 0; i < 8; i++) begin
            check("R3 order", {24'b0, txq_byte}, 32'h10 + i);
            line_pop();
        end
        check("R3 ninth dropped", {31'b0, txq_valid}, 0);
        bus_read(5'h00, 32'h0, "R3 not full");

        // R11: pending register ignores writes
        bus_write(5'h14, 32'h0);
        bus_read(5'h14, 32'h1, "R11 readonly");

        // R7 / R9: receive side
        bus_write(5'h0C, 32'hFFF8_FFF1);
        bus_read(5'h0C, 32'h0000_0001, "R7 rx cfg");
        check("R7 rx_enable", {31'b0, rx_enable}, 1);
        bus_write(5'h10, 32'h2);
        line_push(8'h5A);
        bus_read(5'h14, 32'h3, "R9 one byte pends");
        check("R10 enabled rx", {31'b0, irq}, 1);
        bus_write(5'h0C, 32'h0002_0001);
        check("R9 threshold 2", {31'b0, irq}, 0);
        line_push(8'h5B);
        line_push(8'h5C);
        check("R9 above threshold", {31'b0, irq}, 1);
        bus_read(5'h04, 32'h5A, "R4 first");
        check("R9 after pop", {31'b0, irq}, 0);
        bus_read(5'h04, 32'h5B, "R4 second");
        bus_read(5'h04, 32'h5C, "R4 third");
        bus_read(5'h04, 32'h8000_0000, "R4 empty");
        bus_read(5'h04, 32'h8000_0000, "R4 empty again");

        // R5: overflow drop
        for (int i = 0; i < 9; i++) line_push(8'h60 + 8'(i));
        for (int i = 0; i < 8; i++) bus_read(5'h04, 32'h60 + i, "R5 order");
        bus_read(5'h04, 32'h8000_0000, "R5 ninth dropped");

        // R12: divisor
        bus_write(5'h18, 32'hDEAD_BEEF);
        bus_read(5'h18, 32'h0000_BEEF, "R12 readback");
        check("R12 port", {16'b0, baud_div}, 32'hBEEF);

        // R13: idle cycle gives zero read data
        @(negedge clk); @(negedge clk);
        check("R13 idle", bus_rdata, 0);

        repeat (3) @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R13: actual %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule